// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Sequencer

This block runs the pin-level cycles of an asynchronous DRAM that has one row strobe, one column strobe and one write enable, all active low. A client hands over one request at a time: a byte read, a byte write or a refresh. Read and write requests carry a flat address. The sequencer cuts that address into a row part and a column part and places them one after the other on a shared address bus. It drives the byte bus only while writing and captures it while reading.

The split point comes from a run-time input, `half_bits`, which gives the number of address bits in each half. Every step of a cycle lasts `STEP_CYC` clock cycles. This lets a fast system clock meet the memory's strobe widths and address setup times. Refresh uses strobes only: the column strobe goes low before the row strobe, and the address bus is left as it was.

Top module: `dram_seq`

## Requirements
- R1: After reset `ras_n`, `cas_n` and `we_n` are 1, `dq_oe`, `rd_valid` and `cfg_err` are 0, `req_ready` is 1, and `dram_addr`, `dq_out` and `rd_data` are 0.
- R2: With N = `half_bits`, the row address driven is `(req_addr >> N) & (2^N - 1)` and the column address is `req_addr & (2^N - 1)`. Each is placed on the low bits of `dram_addr`, and `dram_addr` does not change while `cas_n` is 0.
- R3: A write (`req_op` = 2'b01) first drives `dq_out` with the data, sets `dq_oe` = 1 and `we_n` = 0. It then puts the row on `dram_addr`, drops `ras_n`, puts the column on `dram_addr`, and drops `cas_n`, in that order.
- R4: A write closes by raising `ras_n`, then `cas_n`, then clearing `dq_oe`, then raising `we_n`. `dq_oe` is 1 only while `we_n` is 0.
- R5: A read (`req_op` = 2'b00) first makes sure `we_n` = 1 and `dq_oe` = 0. It then drives the row, drops `ras_n`, drives the column and drops `cas_n`.
- R6: A read captures `dq_in` into `rd_data` while both strobes are low and marks it with a one-cycle `rd_valid` pulse. It then raises `ras_n`, then `cas_n`.
- R7: A refresh (`req_op[1]` = 1) drops `cas_n`, drops `ras_n`, raises `cas_n`, then raises `ras_n`. `we_n` stays 1 and `dram_addr` keeps its previous value throughout.
- R8: The first action of a request occurs exactly `STEP_CYC` cycles after the accepting edge. Each later action occurs exactly `STEP_CYC` cycles after the previous one, and the outputs hold steady in between.
- R9: `req_ready` is 0 from the accepting edge until the last action of the cycle and is 1 again in the cycle after it. A request presented while `req_ready` is 0 is ignored.
- R10: A request with `half_bits` of 0 or above `MAX_HALF` (12 by default) is not accepted. `cfg_err` pulses for one cycle, `req_ready` stays 1, and no strobe or write enable moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_op | input | 2 | 00 read, 01 write, 1x refresh |
| req_addr | input | 2*MAX_HALF | Flat byte address |
| req_wdata | input | DATA_W | Write byte |
| half_bits | input | clog2(MAX_HALF+1) | Address bits per half |
| cfg_err | output | 1 | One-cycle pulse on a rejected request |
| rd_valid | output | 1 | One-cycle pulse, read byte ready |
| rd_data | output | DATA_W | Read byte |
| dram_addr | output | MAX_HALF | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_oe | output | 1 | Data bus output enable |
| dq_out | output | DATA_W | Data bus value while enabled |
| dq_in | input | DATA_W | Data bus value sampled on reads |

## Verification
The bench builds the block with `STEP_CYC` = 3 and the default `MAX_HALF` = 12. A step of three cycles lets the bench check, one cycle before each action, that nothing has moved yet, and then check right after it. With the full 12-bit halves, splits at 1, 4, 8, 9 and 12 bits can be exercised, including both the widest and the narrowest mask. The values 0 and 13 drive the reject path.

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter int MAX_HALF = 12,
  parameter int DATA_W   = 8,
  parameter int STEP_CYC = 2,
  localparam int ADDR_W  = 2 * MAX_HALF,
  localparam int HB_W    = $clog2(MAX_HALF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [HB_W-1:0]   half_bits,
  output logic              cfg_err,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [MAX_HALF-1:0] dram_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  input  logic [DATA_W-1:0] dq_in
);
  localparam int TMR_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic                busy;
  logic [1:0]          op_q;
  logic [3:0]          step;
  logic [3:0]          last_step;
  logic [TMR_W-1:0]    tmr;
  logic [MAX_HALF-1:0] row_q, col_q;
  logic [DATA_W-1:0]   wd_q;
  logic [ADDR_W-1:0]   mask_w, row_w, col_w;
  logic                hb_ok, accept, fire;

  assign hb_ok     = (half_bits != '0) && (int'(half_bits) <= MAX_HALF);
  assign mask_w    = ~({ADDR_W{1'b1}} << half_bits);
  assign row_w     = (req_addr >> half_bits) & mask_w;
  assign col_w     = req_addr & mask_w;
  assign req_ready = !busy;
  assign accept    = req_valid && !busy && hb_ok;
  assign fire      = busy && (tmr == TMR_W'(STEP_CYC - 1));
  assign last_step = op_q[1] ? 4'd3 : (op_q[0] ? 4'd8 : 4'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      op_q      <= '0;
      step      <= '0;
      tmr       <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wd_q      <= '0;
      cfg_err   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      dram_addr <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
    end else begin
      rd_valid <= 1'b0;
      cfg_err  <= req_valid && !busy && !hb_ok;
      if (accept) begin
        busy  <= 1'b1;
        op_q  <= req_op;
        step  <= '0;
        tmr   <= '0;
        row_q <= row_w[MAX_HALF-1:0];
        col_q <= col_w[MAX_HALF-1:0];
        wd_q  <= req_wdata;
      end else if (busy) begin
        if (!fire) begin
          tmr <= tmr + 1'b1;
        end else begin
          tmr  <= '0;
          step <= step + 4'd1;
          if (step == last_step) busy <= 1'b0;
          if (op_q[1]) begin
            case (step)
              4'd0:    cas_n <= 1'b0;
              4'd1:    ras_n <= 1'b0;
              4'd2:    cas_n <= 1'b1;
              default: ras_n <= 1'b1;
            endcase
          end else if (op_q[0]) begin
            case (step)
              4'd0: begin
                dq_out <= wd_q;
                dq_oe  <= 1'b1;
                we_n   <= 1'b0;
              end
              4'd1:    dram_addr <= row_q;
              4'd2:    ras_n <= 1'b0;
              4'd3:    dram_addr <= col_q;
              4'd4:    cas_n <= 1'b0;
              4'd5:    ras_n <= 1'b1;
              4'd6:    cas_n <= 1'b1;
              4'd7:    dq_oe <= 1'b0;
              default: we_n  <= 1'b1;
            endcase
          end else begin
            case (step)
              4'd0: begin
                we_n  <= 1'b1;
                dq_oe <= 1'b0;
              end
              4'd1:    dram_addr <= row_q;
              4'd2:    ras_n <= 1'b0;
              4'd3:    dram_addr <= col_q;
              4'd4:    cas_n <= 1'b0;
              4'd5: begin
                rd_data  <= dq_in;
                rd_valid <= 1'b1;
              end
              4'd6:    ras_n <= 1'b1;
              default: cas_n <= 1'b1;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int MAX_HALF = 12,
  parameter int DATA_W   = 8,
  parameter int STEP_CYC = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                cfg_err,
  input logic                rd_valid,
  input logic [MAX_HALF-1:0] dram_addr,
  input logic                ras_n,
  input logic                cas_n,
  input logic                we_n,
  input logic                dq_oe
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && cas_n && we_n && !dq_oe));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> $stable(dram_addr));

  assert_dq_needs_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);

  assert_sample_in_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!ras_n && !cas_n));

  assert_rdvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_reject_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (req_ready && ras_n && cas_n && we_n));

  generate
    if (STEP_CYC >= 2) begin : g_width
      assert_ras_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ras_n) |=> $stable(ras_n));
      assert_cas_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cas_n) |=> $stable(cas_n));
    end
  endgenerate
endmodule

bind dram_seq dram_seq_chk #(
  .MAX_HALF(MAX_HALF), .DATA_W(DATA_W), .STEP_CYC(STEP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cfg_err(cfg_err),
  .rd_valid(rd_valid), .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .dq_oe(dq_oe)
);

// File: tb/tb_dram_seq.sv
module tb_dram_seq;
  localparam int CLK_P = 10;
  localparam int STEP  = 3;
  localparam int MH    = 12;
  localparam int DW    = 8;
  localparam int AW    = 2 * MH;
  localparam int NV    = 6;

  // {poke, op, hb, addr, wdata, dq_in}
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 2'b01, 4'd12, 24'hABC123, 8'hA5, 8'h00},
    {1'b0, 2'b00, 4'd12, 24'h5A5F0F, 8'h00, 8'h3C},
    {1'b0, 2'b01, 4'd4,  24'hFFFF7E, 8'h0F, 8'h00},
    {1'b1, 2'b10, 4'd8,  24'h123456, 8'h00, 8'h00},
    {1'b0, 2'b00, 4'd1,  24'h000003, 8'h00, 8'hC3},
    {1'b0, 2'b00, 4'd9,  24'h03FFFF, 8'h00, 8'h96}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, cfg_err, rd_valid;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, rd_data, dq_out, dq_in = '0;
  logic [3:0] half_bits = 4'd12;
  logic [MH-1:0] dram_addr;
  logic ras_n, cas_n, we_n, dq_oe;

  int errors = 0, checks = 0;

  logic e_ras, e_cas, e_we, e_oe, e_rdy, e_rv, e_err;
  logic [MH-1:0] e_addr;
  logic [DW-1:0] e_dq, e_rd;

  always #(CLK_P/2) clk = ~clk;

  dram_seq #(.MAX_HALF(MH), .DATA_W(DW), .STEP_CYC(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .half_bits(half_bits), .cfg_err(cfg_err), .rd_valid(rd_valid),
    .rd_data(rd_data), .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dq_oe(dq_oe), .dq_out(dq_out), .dq_in(dq_in)
  );

  function automatic logic [34:0] act();
    return {ras_n, cas_n, we_n, dq_oe, dram_addr, dq_oe ? dq_out : 8'h00,
            req_ready, rd_valid, rd_valid ? rd_data : 8'h00, cfg_err};
  endfunction

  function automatic logic [34:0] exp_v();
    return {e_ras, e_cas, e_we, e_oe, e_addr, e_oe ? e_dq : 8'h00,
            e_rdy, e_rv, e_rv ? e_rd : 8'h00, e_err};
  endfunction

  task automatic check(input string req, input string what);
    checks++;
    if (act() !== exp_v()) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act(), exp_v());
    end
  endtask

  task automatic idle_exp();
    e_ras = 1; e_cas = 1; e_we = 1; e_oe = 0; e_rdy = 1; e_rv = 0; e_err = 0;
  endtask

  task automatic run_req(input logic [1:0] op, input logic [AW-1:0] addr,
                         input logic [DW-1:0] wd, input logic [3:0] hb,
                         input logic [DW-1:0] dqv, input logic poke);
    logic [AW-1:0] mask, row, col;
    int n;
    string tag;
    mask = (24'h1 << hb) - 24'h1;
    row  = (addr >> hb) & mask;
    col  = addr & mask;
    n    = op[1] ? 4 : (op[0] ? 9 : 8);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_wdata = wd;
    half_bits = hb; dq_in = dqv;
    @(negedge clk);
    if (poke) begin
      req_op = 2'b01; req_wdata = 8'hEE;
    end else req_valid = 0;
    e_rdy = 0;
    check("R9", "ready low after accept");
    for (int k = 0; k < n; k++) begin
      repeat (STEP - 1) @(negedge clk);
      e_rv = 0;
      check("R8", "no change before step end");
      @(negedge clk);
      if (poke && k == 0) req_valid = 0;
      e_rdy = (k == n - 1);
      if (op[1]) begin
        tag = "R7";
        case (k)
          0: e_cas = 0;
          1: e_ras = 0;
          2: e_cas = 1;
          default: e_ras = 1;
        endcase
      end else if (op[0]) begin
        tag = (k < 5) ? "R3" : "R4";
        case (k)
          0: begin e_dq = wd; e_oe = 1; e_we = 0; end
          1: begin e_addr = row[MH-1:0]; tag = "R2"; end
          2: e_ras = 0;
          3: begin e_addr = col[MH-1:0]; tag = "R2"; end
          4: e_cas = 0;
          5: e_ras = 0 ? 0 : 1;
          6: e_cas = 1;
          7: e_oe = 0;
          default: e_we = 1;
        endcase
      end else begin
        tag = (k < 5) ? "R5" : "R6";
        case (k)
          0: begin e_we = 1; e_oe = 0; end
          1: begin e_addr = row[MH-1:0]; tag = "R2"; end
          2: e_ras = 0;
          3: begin e_addr = col[MH-1:0]; tag = "R2"; end
          4: e_cas = 0;
          5: begin e_rd = dqv; e_rv = 1; end
          6: e_ras = 1;
          default: e_cas = 1;
        endcase
      end
      check(tag, $sformatf("op=%0d step=%0d", op, k));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_exp();
    e_addr = '0; e_dq = '0; e_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "reset state");

    for (int v = 0; v < NV; v++)
      run_req(VEC[v][45:44], VEC[v][39:16], VEC[v][15:8], VEC[v][43:40],
              VEC[v][7:0], VEC[v][46]);

    // R9: back-to-back request accepted at once after the previous ends
    run_req(2'b10, '0, '0, 4'd3, '0, 1'b0);

    // R10: out-of-range split settings are rejected
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      req_valid = 1; req_op = 2'b01; half_bits = (b == 0) ? 4'd0 : 4'd13;
      @(negedge clk);
      req_valid = 0;
      e_err = 1; e_rdy = 1;
      check("R10", "reject pulse");
      repeat (STEP + 1) @(negedge clk);
      e_err = 0;
      check("R10", "no cycle started after reject");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule